// File: doc/BRIEF.md
# Fused Coprocessor Instruction Push Unpacker

This block sits between a processor's decode stage and one thread's coprocessor instruction queue. The processor can hand over as many as four adjacent custom instruction words in one cycle. Each custom word lives in the opcode space that compressed instructions would occupy; the processor does not implement compressed instructions. A word is recognised as custom when its two lowest bits are anything other than `2'b11`. The coprocessor instruction was rotated left by two bits when the custom word was built. The block rotates every recognised word right by two bits to restore the original instruction.

The restored words of a group go into a 32-entry queue together, in one cycle, in program order. The queue hands at most one word per cycle to the downstream expander through a valid/ready pair. A group goes in only if the queue has room for every word in it. If it does not, the block raises `stall` and the processor holds the same group on its lanes until the stall clears. A group is never split.

Top module: `fusedpush_top`

## Requirements
- R1: After synchronous reset the queue is empty. `deq_vld` is 0, and `stall` is 0 while no lane carries a custom word.
- R2: Every enqueued word is its lane word rotated right by 2 bits, that is `{w[1:0], w[31:2]}`.
- R3: A lane takes part only when its bit in `lane_vld` is 1 and its word has bits [1:0] not equal to `2'b11`. A valid lane whose low bits are `2'b11` is never enqueued, and it does not count toward the group size.
- R4: All participating lanes of an accepted group (1 to 4 words) enter the queue in the same cycle, lowest lane number first.
- R5: The queue releases at most one word per cycle, oldest first. `deq_vld` is high whenever the queue holds a word. While `deq_vld` is high and `deq_rdy` is low, `deq_word` does not change.
- R6: A group of N participating words is accepted only if at least N entries are free. Free space is counted at the start of the cycle, and a dequeue in the same cycle does not add to it. Otherwise `stall` is 1 and nothing from the group is enqueued.
- R7: The queue holds exactly 32 words. Thirty-two words are accepted without a stall, and after that any group with at least one participating word stalls.
- R8: `stall` is a combinational function of the present lanes and the present fill level. A cycle with no participating lane never stalls, even when the queue is full.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| lane_vld | input | 4 | Lane occupancy mask, contiguous from lane 0 |
| lane_words | input | 128 | Four 32-bit custom words, lane k at bits [32k+31:32k] |
| stall | output | 1 | Group refused this cycle, so the processor must hold the group |
| deq_vld | output | 1 | Queue head is valid |
| deq_word | output | 32 | Queue head instruction word |
| deq_rdy | input | 1 | Downstream takes the head this cycle |

## Verification
The bench builds the block with its default parameters: four lanes, 32-bit words and a 32-entry queue. Eight full groups therefore reach the full state, which exercises the wrap of the queue pointers and the boundary where the free count is one and a group of two must wait. With these values the bench also shows that a same-cycle dequeue does not let a group in, and that a group made only of non-custom lanes passes through a full queue without a stall.

// File: rtl/fusedpush_pkg.sv
package fusedpush_pkg;
    localparam int LANES  = 4;
    localparam int WORD_W = 32;
    localparam int ROT    = 2;
    localparam int CNT_W  = $clog2(LANES + 1);

    typedef logic [WORD_W-1:0] word_t;

    typedef struct packed {
        logic [CNT_W-1:0]       n;
        word_t [LANES-1:0]      w;
    } group_t;

    function automatic word_t unrotate(word_t v);
        return {v[ROT-1:0], v[WORD_W-1:ROT]};
    endfunction

    function automatic logic is_custom(word_t v);
        return v[1:0] != 2'b11;
    endfunction
endpackage

// File: rtl/fp_lane_decode.sv
module fp_lane_decode
    import fusedpush_pkg::*;
(
    input  logic [LANES-1:0]        vld,
    input  logic [LANES*WORD_W-1:0] words,
    output logic [LANES-1:0]        qual,
    output word_t [LANES-1:0]       rec
);
    for (genvar g = 0; g < LANES; g++) begin : g_lane
        word_t raw;
        assign raw     = words[g*WORD_W +: WORD_W];
        assign qual[g] = vld[g] && is_custom(raw);
        assign rec[g]  = unrotate(raw);
    end
endmodule

// File: rtl/fp_compact.sv
module fp_compact
    import fusedpush_pkg::*;
(
    input  logic [LANES-1:0]  qual,
    input  word_t [LANES-1:0] rec,
    output group_t            grp
);
    always_comb begin
        int idx;
        idx = 0;
        grp = '0;
        for (int j = 0; j < LANES; j++) begin
            if (qual[j]) begin
                grp.w[idx] = rec[j];
                idx = idx + 1;
            end
        end
        grp.n = CNT_W'(idx);
    end
endmodule

// File: rtl/fp_fifo.sv
module fp_fifo
    import fusedpush_pkg::*;
#(
    parameter int DEPTH = 32,
    localparam int AW   = $clog2(DEPTH),
    localparam int FW   = $clog2(DEPTH + 1)
) (
    input  logic          clk,
    input  logic          rst,
    input  logic          push,
    input  group_t        grp,
    input  logic          pop_rdy,
    output logic          head_vld,
    output word_t         head,
    output logic [FW-1:0] fill
);
    word_t         mem [DEPTH];
    logic [AW-1:0] wr_ptr, rd_ptr;
    logic          pop;

    assign head_vld = fill != '0;
    assign head     = mem[rd_ptr];
    assign pop      = head_vld && pop_rdy;

    always_ff @(posedge clk) begin
        if (push) begin
            for (int k = 0; k < LANES; k++) begin
                if (k < int'(grp.n)) mem[wr_ptr + AW'(k)] <= grp.w[k];
            end
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            wr_ptr <= '0;
            rd_ptr <= '0;
            fill   <= '0;
        end else begin
            if (push) wr_ptr <= wr_ptr + AW'(grp.n);
            if (pop)  rd_ptr <= rd_ptr + 1'b1;
            fill <= fill + (push ? FW'(grp.n) : FW'(0)) - FW'(pop);
        end
    end

    // R7
    no_overflow_chk: assert property (@(posedge clk) disable iff (rst)
        fill <= FW'(DEPTH));

    // R5
    head_hold_chk: assert property (@(posedge clk) disable iff (rst)
        (head_vld && !pop_rdy) |=> (head_vld && $stable(head)));

    // R4
    fill_step_chk: assert property (@(posedge clk) disable iff (rst)
        !$past(rst) |-> (fill <= $past(fill) + FW'(LANES)));
endmodule

// File: rtl/fusedpush_top.sv
module fusedpush_top
    import fusedpush_pkg::*;
#(
    parameter int DEPTH = 32,
    localparam int FW   = $clog2(DEPTH + 1)
) (
    input  logic                    clk,
    input  logic                    rst,
    input  logic [LANES-1:0]        lane_vld,
    input  logic [LANES*WORD_W-1:0] lane_words,
    output logic                    stall,
    output logic                    deq_vld,
    output logic [WORD_W-1:0]       deq_word,
    input  logic                    deq_rdy
);
    logic [LANES-1:0]  qual;
    word_t [LANES-1:0] rec;
    group_t            grp;
    logic [FW-1:0]     fill;
    logic [FW-1:0]     free;
    logic              push;

    fp_lane_decode u_dec (
        .vld   (lane_vld),
        .words (lane_words),
        .qual  (qual),
        .rec   (rec)
    );

    fp_compact u_cmp (
        .qual (qual),
        .rec  (rec),
        .grp  (grp)
    );

    assign free  = FW'(DEPTH) - fill;
    assign stall = FW'(grp.n) > free;
    assign push  = !stall && (grp.n != '0);

    fp_fifo #(.DEPTH(DEPTH)) u_fifo (
        .clk      (clk),
        .rst      (rst),
        .push     (push),
        .grp      (grp),
        .pop_rdy  (deq_rdy),
        .head_vld (deq_vld),
        .head     (deq_word),
        .fill     (fill)
    );

    // R6
    stall_noenq_chk: assert property (@(posedge clk) disable iff (rst)
        stall |=> (fill == $past(fill) - FW'($past(deq_vld && deq_rdy))));

    // R8
    idle_nostall_chk: assert property (@(posedge clk) disable iff (rst)
        (lane_vld == '0) |-> !stall);
endmodule

// File: tb/fusedpush_top_test.sv
module fusedpush_top_test;
    logic         clk = 0;
    logic         rst;
    logic [3:0]   lane_vld;
    logic [127:0] lane_words;
    logic         stall;
    logic         deq_vld;
    logic [31:0]  deq_word;
    logic         deq_rdy;

    int total = 0;
    int bad   = 0;
    logic [31:0] expq[$];

    always #4 clk = ~clk;

    fusedpush_top uut (
        .clk(clk), .rst(rst), .lane_vld(lane_vld), .lane_words(lane_words),
        .stall(stall), .deq_vld(deq_vld), .deq_word(deq_word), .deq_rdy(deq_rdy)
    );

    function automatic logic [31:0] rotr2(logic [31:0] v);
        return (v >> 2) | (v << 30);
    endfunction

    function automatic logic [31:0] mk(int s, bit plain);
        logic [31:0] v;
        v = (32'h9E3779B9 * (s + 7)) ^ (32'(s) << 9);
        if (plain) v[1:0] = 2'b11;
        else if (v[1:0] == 2'b11) v[1:0] = 2'b01;
        return v;
    endfunction

    task automatic chk(bit ok, string req, logic [31:0] act, logic [31:0] exp);
        total++;
        if (!ok) begin
            bad++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    // One cycle: monitor compares the queue head, driver applies a group
    // and records the words it expects to be accepted.
    task automatic step(logic [3:0] vld, logic [127:0] words, bit rdy);
        int n;
        bit st_exp;
        @(negedge clk);
        // monitor: R2 R4 R5 ordering and content at the head
        if (expq.size() == 0) begin
            chk(deq_vld == 1'b0, "R5 empty head", 32'(deq_vld), 32'd0);
        end else begin
            chk(deq_vld == 1'b1, "R5 head valid", 32'(deq_vld), 32'd1);
            chk(deq_word == expq[0], "R2/R4/R5 head word", deq_word, expq[0]);
        end
        lane_vld   = vld;
        lane_words = words;
        deq_rdy    = rdy;
        #1;
        n = 0;
        for (int j = 0; j < 4; j++)
            if (vld[j] && words[j*32 +: 2] != 2'b11) n++;
        st_exp = n > (32 - expq.size());
        // R6 R7 R8: stall from group size against start-of-cycle free space
        chk(stall == st_exp, "R6/R7/R8 stall", 32'(stall), 32'(st_exp));
        @(posedge clk);
        if (rdy && expq.size() > 0) void'(expq.pop_front());
        if (!st_exp)
            for (int j = 0; j < 4; j++)
                if (vld[j] && words[j*32 +: 2] != 2'b11)
                    expq.push_back(rotr2(words[j*32 +: 32]));
    endtask

    function automatic logic [127:0] pack4(logic [31:0] a, logic [31:0] b,
                                           logic [31:0] c, logic [31:0] d);
        return {d, c, b, a};
    endfunction

    initial begin
        #(8 * 200000);
        bad++;
        total++;
        $display("FAIL watchdog expired actual=%0d expected=%0d", 1, 0);
        $display("  test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    initial begin
        int s;
        s = 0;
        rst = 1; lane_vld = '0; lane_words = '0; deq_rdy = 0;
        repeat (3) @(posedge clk);
        @(negedge clk);
        rst = 0;
        // R1: reset state
        #1;
        chk(deq_vld == 1'b0, "R1 deq_vld after reset", 32'(deq_vld), 32'd0);
        chk(stall == 1'b0, "R1 stall after reset", 32'(stall), 32'd0);

        // single-lane pushes, R2
        for (int i = 0; i < 5; i++) begin
            step(4'b0001, pack4(mk(s, 0), 0, 0, 0), 1); s++;
        end
        step(4'b0000, '0, 1);
        // R3: mixed custom and plain lanes
        step(4'b1111, pack4(mk(s, 0), mk(s+1, 1), mk(s+2, 0), mk(s+3, 1)), 0); s += 4;
        step(4'b0111, pack4(mk(s, 1), mk(s+1, 1), mk(s+2, 0), mk(s+3, 0)), 1); s += 4;
        repeat (4) step(4'b0000, '0, 1);

        // R7: fill to 32 with full groups, no draining
        for (int i = 0; i < 8; i++) begin
            step(4'b1111, pack4(mk(s, 0), mk(s+1, 0), mk(s+2, 0), mk(s+3, 0)), 0); s += 4;
        end
        step(4'b0001, pack4(mk(s, 0), 0, 0, 0), 0);                 // full: stall
        // R8: only plain lanes while full, no stall
        step(4'b1111, pack4(mk(s, 1), mk(s+1, 1), mk(s+2, 1), mk(s+3, 1)), 0);
        // R6: dequeue in same cycle does not admit the group
        step(4'b0001, pack4(mk(s, 0), 0, 0, 0), 1);
        step(4'b0011, pack4(mk(s, 0), mk(s+1, 0), 0, 0), 0);        // free=1, N=2
        step(4'b0001, pack4(mk(s, 0), 0, 0, 0), 0); s += 2;         // accepted
        step(4'b0001, pack4(mk(s, 0), 0, 0, 0), 0);                 // full again

        // drain with mixed traffic
        for (int i = 0; i < 160; i++) begin
            logic [3:0] m;
            case (i % 5)
                0: m = 4'b0001;
                1: m = 4'b0011;
                2: m = 4'b0111;
                3: m = 4'b1111;
                default: m = 4'b0000;
            endcase
            step(m, pack4(mk(s, (i % 7) == 3), mk(s+1, 0), mk(s+2, (i % 3) == 1), mk(s+3, 0)),
                 (i % 4) != 2);
            s += 4;
        end
        while (expq.size() > 0) step(4'b0000, '0, 1);
        step(4'b0000, '0, 1);

        $display("  test done: total=%0d bad=%0d", total, bad);
        $finish;
    end
endmodule